// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects a clocked host to a 256K-word by 16-bit asynchronous static RAM. The host offers one request at a time with a ready/valid handshake. Each request carries a read/write flag, an 18-bit word address, 16-bit write data and a 2-bit lane mask. Mask bit 0 selects data bits 7:0 and mask bit 1 selects bits 15:8. Reads return their data with a single-cycle valid pulse. On the memory side the controller drives the address, the active-low chip select, write strobe, output enable and the two lane enables. The shared data bus is split into an outgoing value, a drive enable and an incoming value, so a pad ring can build the tristate buffer outside the block.

Timing comes from parameters in picoseconds: the clock period, the minimum write-strobe width, the data setup before the write ends, and the address-to-data read access. Each one is rounded up to whole clock periods. The write-strobe low phase lasts the larger of the strobe count and the setup count. A read holds the memory selected for the access count. The data is captured on the edge that ends that count. The controller enables its data drivers only while the memory's output enable is high. Every read is followed by one idle turnaround cycle, so the two sides never drive the bus at the same time. A request whose mask is all zero never selects the memory.

The state machine has six states:
- IDLE: ready is high.
- WSET: write setup, with the memory selected and data driven.
- WPUL: write pulse, with the write strobe low.
- WEND: write end, with the strobe high and address and data still held.
- RACC: read access.
- TURN: bus turnaround.

Its transitions are:
- IDLE→WSET on an accepted write with a nonzero mask.
- IDLE→RACC on an accepted read with a nonzero mask.
- IDLE→IDLE on an accepted request with an all-zero mask.
- WSET→WPUL always.
- WPUL→WEND when the pulse timer expires.
- WEND→IDLE always.
- RACC→TURN when the access timer expires.
- TURN→IDLE always.

Top module: `asram_lane_ctrl`

## Requirements
- R1: While reset is low and right after it, chip select, write strobe, output enable and both lane enables are high (inactive), the data drive enable is 0, the response valid is 0 and ready is 1.
- R2: A write with a nonzero mask gives the following sequence. First, one cycle with chip select low, write strobe high, output enable high and data driven. Then the write strobe is low for max(ceil(pulse/period), ceil(setup/period)) cycles, which is 2 at the default timing. Then one cycle with the strobe high and chip select still low. Then chip select goes high, the drive is released and ready returns.
- R3: While chip select is low, the low-lane enable (bits 7:0) is low exactly when mask bit 0 is 1, and the high-lane enable (bits 15:8) is low exactly when mask bit 1 is 1.
- R4: While the write strobe is low, the memory address equals the request address and the driven data equals the request write data, and neither changes.
- R5: A read with a nonzero mask holds chip select and output enable low and the write strobe high for ceil(access/period) cycles, which is 2 at the default timing, with the data drive enable 0. The data on the bus in the last of those cycles is returned.
- R6: In returned read data, a lane whose mask bit is 0 reads as zero, whatever the bus carries on that lane.
- R7: After a read, chip select and output enable are high for one turnaround cycle with ready still low. The drive enable never rises unless output enable was high in the cycle before, and the controller never drives while the memory drives.
- R8: A request with mask 2'b00 never lowers chip select and leaves ready high. A write of this kind changes nothing in memory. A read of this kind raises response valid in the next cycle with data 0.
- R9: Response valid is high for exactly one cycle per read.
- R10: The write strobe is low only while chip select is low, output enable is high and the controller drives the bus.
- R11: Ready is low for the whole of a nonzero-mask operation, and a request presented while ready is low is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | High-lane enable, active low |
| mem_lb_n | output | 1 | Low-lane enable, active low |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The memory pins are decoded directly from the state, so a wrong state shows on chip select, the write strobe or output enable in the same cycle. A wrong timer load shows as a strobe or access window of the wrong length, and this is visible on the first operation of that kind. A stuck or skipped turnaround state shows within one cycle: either ready rises while output enable has just risen, or the drive enable rises straight after a read. A wrong latched mask shows on the lane enables in the first selected cycle, and later as nonzero data in a masked lane.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPUL,
        ST_WEND,
        ST_RACC,
        ST_TURN
    } asram_state_t;

    function automatic int cycles_for(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction
endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/asram_rdcap.sv
`timescale 1ns/1ps
module asram_rdcap
    import asram_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_en,
    input  logic                    empty_en,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic                    rsp_valid,
    output logic [LANES*LANE_W-1:0] rsp_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= cap_en | empty_en;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rsp_data[g*LANE_W +: LANE_W] <= '0;
            end else if (cap_en) begin
                rsp_data[g*LANE_W +: LANE_W] <= lane_en[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end else if (empty_en) begin
                rsp_data[g*LANE_W +: LANE_W] <= '0;
            end
        end
    end
endmodule

// File: rtl/asram_lane_ctrl.sv
`timescale 1ns/1ps
module asram_lane_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int CLK_PS    = 8000,
    parameter int T_PWE_PS  = 10000,
    parameter int T_SD_PS   = 7000,
    parameter int T_AA_PS   = 12000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [15:0]       mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_i
);
    localparam int PWE_CYC   = cycles_for(T_PWE_PS, CLK_PS);
    localparam int SD_CYC    = cycles_for(T_SD_PS, CLK_PS);
    localparam int PULSE_RAW = (PWE_CYC > SD_CYC) ? PWE_CYC : SD_CYC;
    localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : PULSE_RAW;
    localparam int ACC_RAW   = cycles_for(T_AA_PS, CLK_PS);
    localparam int ACC_CYC   = (ACC_RAW < 1) ? 1 : ACC_RAW;
    localparam int MAX_CYC   = (PULSE_CYC > ACC_CYC) ? PULSE_CYC : ACC_CYC;
    localparam int CNT_W     = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    asram_state_t state, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       wdata_q;
    logic [LANES-1:0]  mask_q;
    logic              accept, t_load, t_done, cap_en, empty_en;
    logic [CNT_W-1:0]  t_val;

    assign accept   = req_valid && req_ready;
    assign empty_en = accept && !req_write && (req_mask == '0);
    assign cap_en   = (state == ST_RACC) && t_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // request register, loaded on every accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    // next state and timer loads
    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (accept && (req_mask != '0)) begin
                    if (req_write) begin
                        nxt = ST_WSET;
                    end else begin
                        nxt    = ST_RACC;
                        t_load = 1'b1;
                        t_val  = CNT_W'(ACC_CYC - 1);
                    end
                end
            end
            ST_WSET: begin
                nxt    = ST_WPUL;
                t_load = 1'b1;
                t_val  = CNT_W'(PULSE_CYC - 1);
            end
            ST_WPUL: if (t_done) nxt = ST_WEND;
            ST_WEND: nxt = ST_IDLE;
            ST_RACC: if (t_done) nxt = ST_TURN;
            ST_TURN: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // pin decode
    always_comb begin
        req_ready = 1'b0;
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_WSET: begin mem_ce_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WPUL: begin mem_ce_n = 1'b0; mem_we_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WEND: begin mem_ce_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_RACC: begin mem_ce_n = 1'b0; mem_oe_n = 1'b0; end
            ST_TURN: ;
            default: ;
        endcase
        mem_lb_n = mem_ce_n | ~mask_q[0];
        mem_ub_n = mem_ce_n | ~mask_q[1];
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;

    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    asram_rdcap u_rdcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .empty_en  (empty_en),
        .lane_en   (mask_q),
        .dq_in     (mem_dq_i),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_rdata)
    );

    assert_lane_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !(mem_ub_n && mem_lb_n));

    assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |->
            ($stable(mem_addr) && $stable(mem_dq_o) && $stable({mem_ub_n, mem_lb_n})));

    assert_read_nodrive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

    assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(mem_oe_n) && mem_oe_n));

    assert_empty_no_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_mask == 2'b00)) |=> (mem_ce_n && req_ready));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_we_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    assert_busy_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);
endmodule

// File: tb/sim_asram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_asram_lane_ctrl;
    localparam int EXP_PULSE = 2;   // max(ceil(10/8), ceil(7/8))
    localparam int EXP_ACC   = 2;   // ceil(12/8)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0] mem_dq_o, mem_dq_i;

    int  errors = 0;
    int  checks = 0;
    bit  finished = 1'b0;

    logic [15:0] mem_arr [0:255];
    logic        mem_drv;

    always #4 clk = ~clk;

    asram_lane_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // memory model: drives selected lanes on read, filler A5 on the others
    assign mem_drv  = !mem_ce_n && !mem_oe_n && mem_we_n && !(mem_ub_n && mem_lb_n);
    assign mem_dq_i = { (!mem_ub_n ? mem_arr[mem_addr[7:0]][15:8] : 8'hA5),
                        (!mem_lb_n ? mem_arr[mem_addr[7:0]][7:0]  : 8'hA5) };

    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0) begin
            if (!mem_lb_n) mem_arr[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
            if (!mem_ub_n) mem_arr[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
        end
    end

    // R7: never both sides on the bus
    always @(negedge clk) begin
        if (rst_n && mem_dq_oe && mem_drv) begin
            checks++;
            errors++;
            $display("FAIL R7 contention: actual=1 expected=0");
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 pins in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}, 5'b11111);
        chk("R1 drive/valid/ready in reset", {mem_dq_oe, rsp_valid, req_ready}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pins after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid, req_ready}, 6'b111001);
    endtask

    task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        chk("R11 ready before write", req_ready, 1'b1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        if (m == 2'b00) begin
            chk("R8 empty write no select", {mem_ce_n, req_ready, rsp_valid}, 3'b110);
            return;
        end
        chk("R2 setup cycle ce/we/oe/drive", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0111);
        chk("R3 lane enables", {mem_ub_n, mem_lb_n}, {~m[1], ~m[0]});
        chk("R11 busy ready low", req_ready, 1'b0);
        for (int i = 0; i < EXP_PULSE; i++) begin
            @(negedge clk);
            chk("R2 strobe low", {mem_ce_n, mem_we_n}, 2'b00);
            chk("R4 addr/data held", {14'b0, mem_addr, mem_dq_o}, {14'b0, a, d});
        end
        @(negedge clk);
        chk("R2 end cycle strobe high ce low", {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b011);
        @(negedge clk);
        chk("R2 release", {mem_ce_n, mem_dq_oe, req_ready}, 3'b101);
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] m, input logic [15:0] exp);
        @(negedge clk);
        chk("R11 ready before read", req_ready, 1'b1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        if (m == 2'b00) begin
            chk("R8 empty read response", {mem_ce_n, req_ready, rsp_valid}, 3'b111);
            chk("R8 empty read data", rsp_rdata, 16'h0000);
            @(negedge clk);
            chk("R9 empty read pulse ends", rsp_valid, 1'b0);
            return;
        end
        for (int i = 0; i < EXP_ACC; i++) begin
            if (i > 0) @(negedge clk);
            chk("R5 access window", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 5'b00100);
            chk("R3 read lanes", {mem_ub_n, mem_lb_n}, {~m[1], ~m[0]});
        end
        @(negedge clk);
        chk("R9 valid pulse", rsp_valid, 1'b1);
        chk("R6 read data", rsp_rdata, exp);
        chk("R7 turnaround", {mem_ce_n, mem_oe_n, req_ready, mem_dq_oe}, 4'b1100);
        @(negedge clk);
        chk("R9 pulse one cycle", {rsp_valid, req_ready}, 2'b01);
    endtask

    task automatic t_full_word();
        do_write(18'h00012, 16'hBEEF, 2'b11);
        do_read(18'h00012, 2'b11, 16'hBEEF);
        do_write(18'h2A000, 16'h0F1E, 2'b11);   // write right after read
        do_read(18'h2A000, 2'b11, 16'h0F1E);
    endtask

    task automatic t_lanes();
        do_write(18'h00034, 16'h1234, 2'b11);
        do_write(18'h00034, 16'hFFCD, 2'b01);
        do_read(18'h00034, 2'b11, 16'h12CD);
        do_read(18'h00034, 2'b10, 16'h1200);
        do_read(18'h00034, 2'b01, 16'h00CD);
        do_write(18'h00034, 16'h9900, 2'b10);
        do_read(18'h00034, 2'b11, 16'h99CD);
    endtask

    task automatic t_empty();
        do_write(18'h00034, 16'h0000, 2'b00);
        do_read(18'h00034, 2'b00, 16'h0000);
        do_read(18'h00034, 2'b11, 16'h99CD);    // R8 memory untouched
    endtask

    task automatic t_busy_ignored();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00040; req_wdata = 16'h5555; req_mask = 2'b11;
        @(negedge clk);
        req_addr = 18'h00041; req_wdata = 16'h6666;
        for (int i = 0; i < EXP_PULSE + 2; i++) begin
            chk("R11 ready low while busy", req_ready, 1'b0);
            @(negedge clk);
        end
        chk("R11 ready back", req_ready, 1'b1);
        req_valid = 1'b0;
        do_read(18'h00041, 2'b11, 16'h0000);
        do_read(18'h00040, 2'b11, 16'h5555);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_arr[i] = 16'h0000;
        t_reset();
        t_full_word();
        t_lanes();
        t_empty();
        t_busy_ignored();
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule